// File: doc/BRIEF.md
# IR Repeat Frame Sorter

This block follows an infrared frame decoder and labels every completed frame either as a fresh key press or as the repetition of a key that is still being held. The decoder hands over a one-cycle frame strobe, the decoded data word and a flag that says the frame began with a short repeat leader. The sorter measures the time since the previous frame, keeps the data of the last full frame for comparison, and writes the verdict into a result register read by the host.

A repeat is recognised in two ways. A frame with the repeat-leader flag is a repeat outright. A full frame whose data equals the stored reference is a repeat when comparison and interval timing are both on and, if the window check is on, the interval is inside a programmable window. The interval counter ticks in fine (10 us) or coarse (100 us) units, derived from the clock by a parameterised prescaler. It saturates rather than wrapping. The result register can be frozen until the host reads it. Frames that arrive while it is frozen are dropped and leave a sticky overrun mark.

Top module: `ir_repeat_sorter`

## Requirements
- R1: The interval counter returns to 0 on every frame strobe and then rises by one per selected tick. With cfg_tick_fine=1 a tick is every TICK_DIV clocks, and with cfg_tick_fine=0 it is every 10*TICK_DIV clocks. A frame arriving n clock edges after the previous one therefore sees floor((n-1)/unit) as its interval. Reset acts as a frame for this count.
- R2: The interval counter stops at its all-ones value (2**CNT_W-1) and does not wrap.
- R3: The reference word is the data of the latest frame without the repeat-leader flag, including frames that were dropped. A full frame is a data-match repeat only when a reference exists, its data equals the reference, cfg_cmp_en=1 and cfg_gap_en=1. The first frame after reset is never a data-match repeat.
- R4: With cfg_win_en=1 a data match is a repeat only if the measured interval is <= cfg_win_limit. With cfg_win_en=0 the interval plays no part in the decision.
- R5: A frame with frm_rpt_leader=1 is stored as a repeat whatever its data. The stored data is the current reference word.
- R6: With cfg_hold_en=1 and res_new=1, a frame with no read in the same cycle is dropped. The result fields stay unchanged and res_overrun becomes 1.
- R7: A host_rd pulse clears res_new and res_overrun. If a frame arrives in the same cycle as the read, the frame is stored, res_new stays 1 and res_overrun is cleared.
- R8: With cfg_hold_en=0 every frame overwrites the result register and sets res_new, and res_overrun is not set.
- R9: After reset all result outputs are 0.
- R10: With cfg_gap_en=0 the interval counter is held at 0, so res_gap reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe for a completed frame |
| frm_data | input | DATA_W | Decoded frame data |
| frm_rpt_leader | input | 1 | Frame started with a repeat leader |
| cfg_gap_en | input | 1 | Enable the interval counter |
| cfg_tick_fine | input | 1 | 1: fine tick (TICK_DIV clocks), 0: coarse tick (10*TICK_DIV clocks) |
| cfg_cmp_en | input | 1 | Enable data-match repeat detection |
| cfg_win_en | input | 1 | Make the interval window part of the decision |
| cfg_win_limit | input | CNT_W | Largest interval still treated as a repeat |
| cfg_hold_en | input | 1 | Freeze the result register until it is read |
| host_rd | input | 1 | Host read strobe for the result register |
| res_data | output | DATA_W | Stored frame data |
| res_repeat | output | 1 | Stored frame is a repeat |
| res_gap | output | CNT_W | Interval measured for the stored frame |
| res_new | output | 1 | Result not yet read |
| res_overrun | output | 1 | A frame was dropped while the result was frozen |

## Verification
The functions that collide are the host read and the arrival of a frame, and they matter most when the result register is frozen and already carries an overrun. The bench drives host_rd and frm_valid in the same cycle. It does this in a directed case, right after a dropped frame, and at random during the seeded stimulus. A per-cycle reference model in the bench judges each collision: the frame must be stored, res_new must stay set and res_overrun must clear. Cycles where only one of the two events occurs are checked in the same run.

// File: rtl/ir_rpt_pkg.sv
package ir_rpt_pkg;
   // Ratio between coarse and fine tick units.
   localparam int TICK_DECADE = 10;

   typedef enum logic {
      TICK_COARSE = 1'b0,
      TICK_FINE   = 1'b1
   } tick_sel_e;
endpackage

// File: rtl/ir_gap_timer.sv
module ir_gap_timer
   import ir_rpt_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter int TICK_DIV = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             count_en,
   input  tick_sel_e        tick_sel,
   output logic [CNT_W-1:0] gap
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] GAP_MAX = '1;

   if (CNT_W < 2)    begin : g_bad_cnt $error("CNT_W must be at least 2"); end
   if (TICK_DIV < 1) begin : g_bad_div $error("TICK_DIV must be at least 1"); end

   logic       tick_fine;
   logic       tick_coarse;
   logic       tick;
   logic [3:0] dec_q;

   // Fine tick: either every clock or from a prescaler
   if (TICK_DIV == 1) begin : g_no_pre
      assign tick_fine = 1'b1;
   end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pre_q <= '0;
         else if (restart)                        pre_q <= '0;
         else if (pre_q == PRE_W'(TICK_DIV - 1))  pre_q <= '0;
         else                                     pre_q <= pre_q + 1'b1;
      end
      assign tick_fine = (pre_q == PRE_W'(TICK_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dec_q <= '0;
      else if (restart)    dec_q <= '0;
      else if (tick_fine)  dec_q <= (dec_q == 4'(TICK_DECADE - 1)) ? '0 : dec_q + 1'b1;
   end

   assign tick_coarse = tick_fine && (dec_q == 4'(TICK_DECADE - 1));
   assign tick        = (tick_sel == TICK_FINE) ? tick_fine : tick_coarse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          gap <= '0;
      else if (restart || !count_en)       gap <= '0;
      else if (tick && gap != GAP_MAX)     gap <= gap + 1'b1;
   end

   // R1: a frame restarts the interval
   a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> gap == '0);
   // R1: the interval moves by at most one step
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && count_en) |=> (gap == $past(gap) || gap == CNT_W'($past(gap) + 1'b1)));
   // R2: saturation
   a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == GAP_MAX && !restart && count_en) |=> gap == GAP_MAX);
   // R10: disabled counter stays at zero
   a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> gap == '0);
endmodule

// File: rtl/ir_repeat_judge.sv
module ir_repeat_judge #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              rpt_leader,
   input  logic              cmp_en,
   input  logic              gap_en,
   input  logic              win_en,
   input  logic [CNT_W-1:0]  win_limit,
   input  logic [CNT_W-1:0]  gap,
   output logic              is_repeat,
   output logic [DATA_W-1:0] sel_data
);
   if (DATA_W < 1) begin : g_bad_data $error("DATA_W must be at least 1"); end

   logic [DATA_W-1:0] ref_q;
   logic              have_q;
   logic              match;
   logic              in_win;

   // Reference follows every full frame, stored or dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         have_q <= 1'b0;
      end else if (frm_valid && !rpt_leader) begin
         ref_q  <= frm_data;
         have_q <= 1'b1;
      end
   end

   assign match     = have_q && (frm_data == ref_q);
   assign in_win    = !win_en || (gap <= win_limit);
   assign is_repeat = rpt_leader || (cmp_en && gap_en && match && in_win);
   assign sel_data  = rpt_leader ? ref_q : frm_data;

   // R3: nothing to match before the first full frame
   a_r3_no_reference: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !have_q && !rpt_leader) |-> !is_repeat);
   // R3: reference captured from full frames
   a_r3_ref_update: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !rpt_leader) |=> (have_q && ref_q == $past(frm_data)));
endmodule

// File: rtl/ir_result_hold.sv
module ir_result_hold #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic              hold_en,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_repeat,
   input  logic [CNT_W-1:0]  in_gap,
   output logic [DATA_W-1:0] res_data,
   output logic              res_repeat,
   output logic [CNT_W-1:0]  res_gap,
   output logic              res_new,
   output logic              res_overrun
);
   logic frozen;
   logic accept;

   assign frozen = hold_en && res_new && !host_rd;
   assign accept = frm_valid && !frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_data   <= '0;
         res_repeat <= 1'b0;
         res_gap    <= '0;
      end else if (accept) begin
         res_data   <= in_data;
         res_repeat <= in_repeat;
         res_gap    <= in_gap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_new     <= 1'b0;
         res_overrun <= 1'b0;
      end else begin
         if (accept)       res_new <= 1'b1;
         else if (host_rd) res_new <= 1'b0;
         if (host_rd)                  res_overrun <= 1'b0;
         else if (frm_valid && frozen) res_overrun <= 1'b1;
      end
   end

   // R6: frozen result drops the frame and flags overrun
   a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && res_new && frm_valid && !host_rd) |=>
         ($stable(res_data) && $stable(res_gap) && res_overrun && res_new));
   // R7: a lone read clears both flags
   a_r7_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !frm_valid) |=> (!res_new && !res_overrun));
   // R7: read and frame together store the frame
   a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && frm_valid) |=> (res_new && !res_overrun && res_data == $past(in_data)));
   // R8: without hold every frame lands
   a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !hold_en) |=> (res_new && res_data == $past(in_data)));
   // R8: overrun never rises without hold
   a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_en && !res_overrun) |=> !res_overrun);
endmodule

// File: rtl/ir_repeat_sorter.sv
module ir_repeat_sorter
   import ir_rpt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 12,
   parameter int TICK_DIV = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_rpt_leader,
   input  logic              cfg_gap_en,
   input  logic              cfg_tick_fine,
   input  logic              cfg_cmp_en,
   input  logic              cfg_win_en,
   input  logic [CNT_W-1:0]  cfg_win_limit,
   input  logic              cfg_hold_en,
   input  logic              host_rd,
   output logic [DATA_W-1:0] res_data,
   output logic              res_repeat,
   output logic [CNT_W-1:0]  res_gap,
   output logic              res_new,
   output logic              res_overrun
);
   logic [CNT_W-1:0]  gap;
   logic              is_repeat;
   logic [DATA_W-1:0] sel_data;
   tick_sel_e         tick_sel;

   assign tick_sel = tick_sel_e'(cfg_tick_fine);

   ir_gap_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (frm_valid),
      .count_en (cfg_gap_en),
      .tick_sel (tick_sel),
      .gap      (gap)
   );

   ir_repeat_judge #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_valid  (frm_valid),
      .frm_data   (frm_data),
      .rpt_leader (frm_rpt_leader),
      .cmp_en     (cfg_cmp_en),
      .gap_en     (cfg_gap_en),
      .win_en     (cfg_win_en),
      .win_limit  (cfg_win_limit),
      .gap        (gap),
      .is_repeat  (is_repeat),
      .sel_data   (sel_data)
   );

   ir_result_hold #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_valid   (frm_valid),
      .hold_en     (cfg_hold_en),
      .host_rd     (host_rd),
      .in_data     (sel_data),
      .in_repeat   (is_repeat),
      .in_gap      (gap),
      .res_data    (res_data),
      .res_repeat  (res_repeat),
      .res_gap     (res_gap),
      .res_new     (res_new),
      .res_overrun (res_overrun)
   );

   // R5: leader frames are stored as repeats
   a_r5_leader: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_rpt_leader && !(cfg_hold_en && res_new && !host_rd)) |=> res_repeat);
   // R3: data matching needs both compare and interval counting
   a_r3_needs_counter: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_rpt_leader && !(cfg_cmp_en && cfg_gap_en)
       && !(cfg_hold_en && res_new && !host_rd)) |=> !res_repeat);
   // R10: with counting off the stored interval is zero
   a_r10_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !cfg_gap_en && !(cfg_hold_en && res_new && !host_rd)) |=> res_gap == '0);
endmodule

// File: tb/ir_repeat_sorter_bench.sv
`timescale 1ns/1ps
module ir_repeat_sorter_bench;
   localparam int DW   = 16;
   localparam int CW   = 6;
   localparam int DIV  = 2;
   localparam int MAXG = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frm_valid = 1'b0;
   logic [DW-1:0] frm_data = '0;
   logic          frm_rpt_leader = 1'b0;
   logic          cfg_gap_en = 1'b1;
   logic          cfg_tick_fine = 1'b1;
   logic          cfg_cmp_en = 1'b1;
   logic          cfg_win_en = 1'b1;
   logic [CW-1:0] cfg_win_limit = 6'd10;
   logic          cfg_hold_en = 1'b0;
   logic          host_rd = 1'b0;
   logic [DW-1:0] res_data;
   logic          res_repeat;
   logic [CW-1:0] res_gap;
   logic          res_new;
   logic          res_overrun;

   always #5 clk = ~clk;

   ir_repeat_sorter #(.DATA_W(DW), .CNT_W(CW), .TICK_DIV(DIV)) u_ir_repeat_sorter (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
      .frm_rpt_leader(frm_rpt_leader), .cfg_gap_en(cfg_gap_en),
      .cfg_tick_fine(cfg_tick_fine), .cfg_cmp_en(cfg_cmp_en),
      .cfg_win_en(cfg_win_en), .cfg_win_limit(cfg_win_limit),
      .cfg_hold_en(cfg_hold_en), .host_rd(host_rd), .res_data(res_data),
      .res_repeat(res_repeat), .res_gap(res_gap), .res_new(res_new),
      .res_overrun(res_overrun)
   );

   int checks = 0;
   int failures = 0;

   // reference model state
   logic [DW-1:0] m_ref = '0;
   bit            m_have = 0;
   logic [DW-1:0] m_data = '0;
   bit            m_rep = 0;
   int            m_gap = 0;
   bit            m_new = 0;
   bit            m_ovr = 0;
   int            edge_no = 0;
   int            last_frame = 0;

   function automatic int gap_expect(int n);
      int unit = DIV * (cfg_tick_fine ? 1 : 10);
      int q = (n - 1) / unit;
      if (q > MAXG) q = MAXG;
      return cfg_gap_en ? q : 0;
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (res_data !== m_data || res_repeat !== m_rep || res_gap !== CW'(m_gap)
          || res_new !== m_new || res_overrun !== m_ovr) begin
         failures++;
         $display("FAIL %s: got data=%h rep=%b gap=%0d new=%b ovr=%b exp data=%h rep=%b gap=%0d new=%b ovr=%b",
                  tag, res_data, res_repeat, res_gap, res_new, res_overrun,
                  m_data, m_rep, m_gap, m_new, m_ovr);
      end
   endtask

   // Called at a negedge; applies one clock edge of stimulus and checks after it.
   task automatic step(input bit f, input logic [DW-1:0] d, input bit l, input bit r,
                       input string tag);
      bit held;
      bit rep;
      int g;
      frm_valid = f; frm_data = d; frm_rpt_leader = l; host_rd = r;
      edge_no++;
      held = cfg_hold_en && m_new && !r;
      if (f) begin
         g   = gap_expect(edge_no - last_frame);
         rep = l || (cfg_cmp_en && cfg_gap_en && m_have && d == m_ref
                     && (!cfg_win_en || g <= int'(cfg_win_limit)));
         if (!held) begin
            m_data = l ? m_ref : d;
            m_rep  = rep;
            m_gap  = g;
         end
         if (!l) begin
            m_ref  = d;
            m_have = 1;
         end
         last_frame = edge_no;
      end
      if (r)             m_ovr = 0;
      else if (f && held) m_ovr = 1;
      if (f && !held)    m_new = 1;
      else if (r)        m_new = 0;
      @(posedge clk);
      @(negedge clk);
      frm_valid = 0; frm_rpt_leader = 0; host_rd = 0;
      compare(tag);
   endtask

   task automatic idle(input int k, input string tag);
      for (int i = 0; i < k; i++) step(0, '0, 0, 0, tag);
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h1F2E3D4C;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;           // counting starts at the next edge
      edge_no = 0; last_frame = 0;
      compare("R9 reset state");

      // directed corner cases
      idle(3, "R9 idle");
      step(1, 16'hA5A5, 0, 0, "R3 first frame not repeat");
      idle(5, "R1 idle");
      step(1, 16'hA5A5, 0, 0, "R4 match inside window");
      idle(40, "R1 idle");
      step(1, 16'hA5A5, 0, 0, "R4 match outside window");
      cfg_win_en = 0;
      idle(40, "R1 idle");
      step(1, 16'hA5A5, 0, 0, "R4 window ignored");
      cfg_gap_en = 0;
      idle(3, "R10 idle");
      step(1, 16'hA5A5, 0, 0, "R10 counter off no repeat");
      cfg_gap_en = 1; cfg_tick_fine = 0;
      idle(45, "R1 coarse idle");
      step(1, 16'h0B0B, 0, 0, "R1 coarse interval");
      idle(2, "R5 idle");
      step(1, 16'hFFFF, 1, 0, "R5 leader repeat");
      cfg_tick_fine = 1;
      idle(200, "R2 idle");
      step(1, 16'h1234, 0, 0, "R2 saturated interval");
      cfg_hold_en = 1;
      step(1, 16'h2222, 0, 0, "R6 frame dropped");
      idle(1, "R6 idle");
      step(1, 16'h3333, 0, 0, "R6 second drop");
      step(1, 16'h4444, 0, 1, "R7 read with frame");
      step(0, '0, 0, 1, "R7 read alone");
      step(1, 16'h5555, 0, 0, "R6 frame after read");
      step(1, 16'h6666, 0, 0, "R6 drop again");
      step(0, '0, 0, 1, "R7 read clears overrun");
      cfg_hold_en = 0;
      step(1, 16'h7777, 0, 0, "R8 overwrite");
      step(1, 16'h7777, 0, 0, "R8 overwrite repeat");

      // seeded random phase
      for (int n = 0; n < 400; n++) begin
         int k = $urandom_range(0, 150);
         for (int i = 0; i < k; i++)
            step(0, '0, 0, ($urandom_range(0, 99) < 3), "R7 random idle");
         step(1, DW'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0),
              ($urandom_range(0, 9) == 0), "R3 R4 R5 R6 random frame");
         if ($urandom_range(0, 4) == 0) begin
            cfg_gap_en    = ($urandom_range(0, 5) != 0);
            cfg_tick_fine = ($urandom_range(0, 3) != 0);
            cfg_cmp_en    = ($urandom_range(0, 5) != 0);
            cfg_win_en    = ($urandom_range(0, 3) != 0);
            cfg_win_limit = CW'($urandom_range(0, 40));
            cfg_hold_en   = ($urandom_range(0, 1) != 0);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule